// File: doc/BRIEF.md
# Video Clamp Pulse Generator

This block turns the horizontal timing inputs of a video front end into the clamp gating pulses. It produces an input clamp pulse, an output clamp pulse and a polarity-corrected internal blanking signal. The inputs are a horizontal sync pin of unknown polarity and a blanking or flyback pin whose polarity is set by a configuration bit. Both pins are synchronised to the system clock. All pulse widths are counted in clock cycles. A parameter gives the number of cycles in one width step of about a third of a microsecond.

The input clamp pulse has three possible sources. It can be a one-shot started by a chosen edge of the rectified sync. It can be a one-shot started by a chosen edge of the blanking pin. It can also be the sync pin passed straight through, with no processing. The output clamp pulse is either a copy of the input clamp pulse or its own one-shot, started where the internal blanking signal rises. Software sets the configuration bits. They are expected to stay steady while pulses are being produced.

Top module: `clamp_pulse_gen`

## Requirements
- R1: `blki` equals the blanking pin as sampled two clock edges earlier, XORed with `cfg_blk_inv`.
- R2: With `cfg_src[1]`=1 (codes 10 and 11), `icp` equals the sync pin as sampled two edges earlier. In this mode the sync is not rectified, not stretched and not shortened.
- R3: With `cfg_src`=00, the block judges sync polarity by itself over each line and takes the shorter phase as the pulse. `cfg_lead_edge`=1 starts `icp` on the start of that pulse, and 0 starts it on the end of that pulse. `icp` goes high 3 clock edges after the pin edge, for either sync polarity.
- R4: With `cfg_src`=01, `icp` starts 3 edges after a rising edge of the blanking pin when `cfg_lead_edge`==`cfg_blk_inv`, and after a falling edge otherwise.
- R5: A triggered pulse lasts (`cfg_width`+1)×STEP_CYCLES cycles, for width codes 0 to 3.
- R6: A trigger edge that arrives while a pulse is active neither restarts nor lengthens that pulse.
- R7: With `cfg_ocp_copy`=1, `ocp` follows `icp` in every source mode.
- R8: With `cfg_ocp_copy`=0, `ocp` is a one-shot of the same width, started 3 edges after `blki` rises. When the blanking pin stays idle, `ocp` stays low.
- R9: During reset and right after it, `icp` and `ocp` are low, and `blki` equals `cfg_blk_inv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hs_pin | input | 1 | Horizontal sync pin, either polarity |
| blk_pin | input | 1 | Blanking or flyback pin |
| cfg_src | input | 2 | Clamp source: 00 sync trigger, 01 blanking trigger, 1x sync pass-through |
| cfg_lead_edge | input | 1 | Edge select bit |
| cfg_blk_inv | input | 1 | Invert the blanking pin to form `blki` |
| cfg_width | input | 2 | Width code for the triggered pulses |
| cfg_ocp_copy | input | 1 | 1: `ocp` copies `icp`; 0: `ocp` is triggered from the blanking edge |
| icp | output | 1 | Input clamp pulse |
| ocp | output | 1 | Output clamp pulse |
| blki | output | 1 | Polarity-corrected blanking |

## Verification
Two functions can fall in the same cycle. The input clamp one-shot and the output clamp one-shot can both be started by the same blanking edge. To provoke this, the bench selects the blanking trigger with the edge set to match the rising edge of `blki`, and sets `ocp` to its own triggered mode. Both pulses must then rise in the same cycle and keep the same length, and `blki` must open one cycle before them. The bench sweeps every combination of inversion, edge and width code. In the mismatched-edge cases it checks that `icp` moves to the other end of the blanking pulse while `ocp` stays where it was.

// File: rtl/cpg_pkg.sv
`timescale 1ns/1ps
package cpg_pkg;
  typedef enum logic [1:0] {
    SRC_HS_TRIG  = 2'b00,
    SRC_BLK_TRIG = 2'b01,
    SRC_HS_PASS  = 2'b10,
    SRC_HS_PASS2 = 2'b11
  } clamp_src_e;

  // Pulse length in cycles for a width code
  function automatic int unsigned pulse_len(input logic [1:0] code, input int unsigned step);
    return (int'(code) + 1) * step;
  endfunction
endpackage

// File: rtl/cpg_sync.sv
`timescale 1ns/1ps
module cpg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/cpg_hs_polarity.sv
`timescale 1ns/1ps
module cpg_hs_polarity #(
  parameter int CNT_W = 12,
  parameter int HYST  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_s,       // synchronised raw sync level
  input  logic line_edge,  // raw rising edge marks a line boundary
  output logic neg_pol     // 1: active pulse is the low phase
);
  localparam logic [CNT_W:0] HYST_V = (CNT_W+1)'(HYST);

  logic [CNT_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic             neg_q, neg_d;
  logic [CNT_W:0]   hi_ext, lo_ext;

  assign hi_ext = {1'b0, hi_q};
  assign lo_ext = {1'b0, lo_q};

  always_comb begin
    hi_d  = hi_q;
    lo_d  = lo_q;
    neg_d = neg_q;
    if (line_edge) begin
      if (!neg_q && (hi_ext > lo_ext + HYST_V))     neg_d = 1'b1;
      else if (neg_q && (lo_ext > hi_ext + HYST_V)) neg_d = 1'b0;
      hi_d = CNT_W'(1);
      lo_d = '0;
    end else if (hs_s) begin
      if (hi_q != '1) hi_d = hi_q + CNT_W'(1);
    end else begin
      if (lo_q != '1) lo_d = lo_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      neg_q <= 1'b0;
    end else begin
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      neg_q <= neg_d;
    end
  end

  assign neg_pol = neg_q;
endmodule

// File: rtl/cpg_oneshot.sv
`timescale 1ns/1ps
module cpg_oneshot
  import cpg_pkg::*;
#(
  parameter int STEP_CYCLES = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig,
  input  logic [1:0] width_code,
  output logic       active
);
  localparam int MAX_LEN = 4 * STEP_CYCLES;
  localparam int TW      = $clog2(MAX_LEN + 1);

  logic [TW-1:0] cnt_q, cnt_d, load_val;
  logic          act_q, act_d, cnt_en;

  assign load_val = TW'(pulse_len(width_code, STEP_CYCLES) - 1);

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (act_q) begin
      cnt_en = 1'b1;
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - TW'(1);
    end else if (trig) begin
      cnt_en = 1'b1;
      act_d  = 1'b1;
      cnt_d  = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/clamp_pulse_gen.sv
`timescale 1ns/1ps
module clamp_pulse_gen
  import cpg_pkg::*;
#(
  parameter int STEP_CYCLES = 17,
  parameter int LINE_CNT_W  = 12,
  parameter int POL_HYST    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hs_pin,
  input  logic       blk_pin,
  input  logic [1:0] cfg_src,
  input  logic       cfg_lead_edge,
  input  logic       cfg_blk_inv,
  input  logic [1:0] cfg_width,
  input  logic       cfg_ocp_copy,
  output logic       icp,
  output logic       ocp,
  output logic       blki
);
  // Reset release synchronisation
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // Pin synchronisation
  logic [1:0] pins_s;
  logic       hs_s, blk_s;
  cpg_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk (clk),
    .rst_n (rst_sync_q),
    .din ({blk_pin, hs_pin}),
    .dout (pins_s)
  );
  assign hs_s  = pins_s[0];
  assign blk_s = pins_s[1];

  // Edge detection registers
  logic hs_d_q, blk_d_q;
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      hs_d_q  <= 1'b0;
      blk_d_q <= 1'b0;
    end else begin
      hs_d_q  <= hs_s;
      blk_d_q <= blk_s;
    end
  end

  logic hs_rise, hs_fall, blk_rise, blk_fall;
  assign hs_rise  =  hs_s  & ~hs_d_q;
  assign hs_fall  = ~hs_s  &  hs_d_q;
  assign blk_rise =  blk_s & ~blk_d_q;
  assign blk_fall = ~blk_s &  blk_d_q;

  // Sync polarity detection
  logic hs_neg;
  cpg_hs_polarity #(.CNT_W(LINE_CNT_W), .HYST(POL_HYST)) u_pol (
    .clk (clk),
    .rst_n (rst_sync_q),
    .hs_s (hs_s),
    .line_edge (hs_rise),
    .neg_pol (hs_neg)
  );

  // Trigger selection
  logic hs_lead, hs_trail, hs_trig, blk_trig, ocp_trig, icp_trig;
  clamp_src_e src;
  assign src      = clamp_src_e'(cfg_src);
  assign hs_lead  = hs_neg ? hs_fall : hs_rise;
  assign hs_trail = hs_neg ? hs_rise : hs_fall;
  assign hs_trig  = cfg_lead_edge ? hs_lead : hs_trail;
  assign blk_trig = (cfg_lead_edge == cfg_blk_inv) ? blk_rise : blk_fall;
  assign ocp_trig = cfg_blk_inv ? blk_fall : blk_rise;

  always_comb begin
    unique case (src)
      SRC_HS_TRIG:  icp_trig = hs_trig;
      SRC_BLK_TRIG: icp_trig = blk_trig;
      default:      icp_trig = 1'b0;
    endcase
  end

  // Pulse timers
  logic icp_t, ocp_t;
  cpg_oneshot #(.STEP_CYCLES(STEP_CYCLES)) u_icp_timer (
    .clk (clk),
    .rst_n (rst_sync_q),
    .trig (icp_trig),
    .width_code (cfg_width),
    .active (icp_t)
  );
  cpg_oneshot #(.STEP_CYCLES(STEP_CYCLES)) u_ocp_timer (
    .clk (clk),
    .rst_n (rst_sync_q),
    .trig (ocp_trig),
    .width_code (cfg_width),
    .active (ocp_t)
  );

  assign blki = blk_s ^ cfg_blk_inv;
  assign icp  = cfg_src[1] ? hs_s : icp_t;
  assign ocp  = cfg_ocp_copy ? icp : ocp_t;
endmodule

// File: rtl/cpg_checker.sv
`timescale 1ns/1ps
module cpg_checker #(
  parameter int STEP_CYCLES = 17
) (
  input logic clk,
  input logic rst_n,
  input logic hs_pin,
  input logic blk_pin,
  input logic src_pass,
  input logic cfg_blk_inv,
  input logic cfg_ocp_copy,
  input logic icp,
  input logic ocp,
  input logic blki
);
  localparam int MAX_LEN = 4 * STEP_CYCLES;
  localparam int RW      = $clog2(MAX_LEN + 2) + 1;

  logic [2:0]    age_q;
  logic [RW-1:0] icp_run_q, ocp_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q     <= '0;
      icp_run_q <= '0;
      ocp_run_q <= '0;
    end else begin
      if (age_q != 3'd7) age_q <= age_q + 3'd1;
      if (src_pass || !icp)     icp_run_q <= '0;
      else if (icp_run_q != '1) icp_run_q <= icp_run_q + RW'(1);
      if (cfg_ocp_copy || !ocp) ocp_run_q <= '0;
      else if (ocp_run_q != '1) ocp_run_q <= ocp_run_q + RW'(1);
    end
  end

  // R1
  blki_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd5) |-> (blki == ($past(blk_pin, 2) ^ cfg_blk_inv)));

  // R2
  pass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd5 && src_pass) |-> (icp == $past(hs_pin, 2)));

  // R5
  icp_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    icp_run_q <= RW'(MAX_LEN));

  // R8
  ocp_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_run_q <= RW'(MAX_LEN));

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 3'd1) |-> (!icp && !ocp));
endmodule

bind clamp_pulse_gen cpg_checker #(.STEP_CYCLES(STEP_CYCLES)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .hs_pin (hs_pin),
  .blk_pin (blk_pin),
  .src_pass (cfg_src[1]),
  .cfg_blk_inv (cfg_blk_inv),
  .cfg_ocp_copy (cfg_ocp_copy),
  .icp (icp),
  .ocp (ocp),
  .blki (blki)
);

// File: tb/clamp_pulse_gen_test.sv
`timescale 1ns/1ps
module clamp_pulse_gen_test;
  localparam int STEP = 4;
  localparam int LINE = 100;
  localparam int P    = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic hs_pin, blk_pin;
  logic [1:0] cfg_src, cfg_width;
  logic cfg_lead_edge, cfg_blk_inv, cfg_ocp_copy;
  logic icp, ocp, blki;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  logic hs_idle, blk_idle;
  int icp_first, icp_cnt, ocp_first, ocp_cnt, blki_first, blki_cnt;

  always #10 clk = ~clk;

  clamp_pulse_gen #(.STEP_CYCLES(STEP), .LINE_CNT_W(10), .POL_HYST(4)) uut (
    .clk (clk), .rst_n (rst_n), .hs_pin (hs_pin), .blk_pin (blk_pin),
    .cfg_src (cfg_src), .cfg_lead_edge (cfg_lead_edge), .cfg_blk_inv (cfg_blk_inv),
    .cfg_width (cfg_width), .cfg_ocp_copy (cfg_ocp_copy),
    .icp (icp), .ocp (ocp), .blki (blki)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit active_at(input int i, input int pat);
    case (pat)
      0: return i < P;
      1: return (i < 2) || (i >= 4 && i < 6);
      default: return 1'b0;
    endcase
  endfunction

  // One line: pulse on the chosen pin, outputs recorded per cycle
  task automatic run_line(input bit on_blk, input int pat);
    icp_first = -1; icp_cnt = 0; ocp_first = -1; ocp_cnt = 0;
    blki_first = -1; blki_cnt = 0;
    for (int i = 0; i < LINE; i++) begin
      @(negedge clk);
      if (icp)  begin icp_cnt++;  if (icp_first < 0)  icp_first = i;  end
      if (ocp)  begin ocp_cnt++;  if (ocp_first < 0)  ocp_first = i;  end
      if (blki) begin blki_cnt++; if (blki_first < 0) blki_first = i; end
      hs_pin  = (!on_blk && active_at(i, pat)) ? ~hs_idle  : hs_idle;
      blk_pin = ( on_blk && active_at(i, pat)) ? ~blk_idle : blk_idle;
    end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    hs_idle = 0; blk_idle = 0;
    hs_pin = 0; blk_pin = 0;
    cfg_src = 2'b00; cfg_width = 2'b01; cfg_lead_edge = 0;
    cfg_blk_inv = 0; cfg_ocp_copy = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk("R9 icp in reset", int'(icp), 0);
    chk("R9 ocp in reset", int'(ocp), 0);
    chk("R9 blki in reset", int'(blki), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R9 icp after reset", int'(icp), 0);
    chk("R9 ocp after reset", int'(ocp), 0);

    // R3 R5 R7 R8: sync-triggered clamp, both polarities, both edges, all widths
    for (int pol = 0; pol < 2; pol++) begin
      hs_idle = pol[0];
      cfg_src = 2'b00;
      repeat (3) run_line(0, 0);
      for (int lead = 0; lead < 2; lead++) begin
        for (int w = 0; w < 4; w++) begin
          cfg_lead_edge = lead[0];
          cfg_width = w[1:0];
          cfg_ocp_copy = w[0];
          run_line(0, 0);
          chk($sformatf("R3 icp start pol=%0d lead=%0d", pol, lead), icp_first, (lead ? 0 : P) + 3);
          chk($sformatf("R5 icp width w=%0d", w), icp_cnt, (w + 1) * STEP);
          if (w[0]) begin
            chk("R7 ocp copy start", ocp_first, icp_first);
            chk("R7 ocp copy width", ocp_cnt, icp_cnt);
          end else begin
            chk("R8 ocp idle without blanking", ocp_cnt, 0);
          end
        end
      end
    end
    hs_idle = 0;
    repeat (3) run_line(0, 2);

    // R1 R4 R5 R8: blanking-triggered clamp with the triggered ocp in the same cycle
    cfg_src = 2'b01;
    cfg_ocp_copy = 0;
    for (int inv = 0; inv < 2; inv++) begin
      cfg_blk_inv = inv[0];
      blk_idle = inv[0];
      run_line(1, 2);
      for (int lead = 0; lead < 2; lead++) begin
        for (int w = 0; w < 4; w++) begin
          int rise_at, exp_first;
          cfg_lead_edge = lead[0];
          cfg_width = w[1:0];
          run_line(1, 0);
          rise_at = inv ? P : 0;
          exp_first = ((lead == inv) ? rise_at : (P - rise_at)) + 3;
          chk($sformatf("R4 icp start inv=%0d lead=%0d", inv, lead), icp_first, exp_first);
          chk($sformatf("R5 icp width blk w=%0d", w), icp_cnt, (w + 1) * STEP);
          chk($sformatf("R8 ocp start inv=%0d", inv), ocp_first, 3);
          chk("R8 ocp width", ocp_cnt, (w + 1) * STEP);
          chk("R1 blki start", blki_first, 2);
          chk("R1 blki width", blki_cnt, P);
        end
      end
    end

    // R6 second trigger edge inside an active pulse
    cfg_blk_inv = 0; blk_idle = 0; cfg_lead_edge = 0; cfg_width = 2'b11;
    run_line(1, 2);
    run_line(1, 1);
    chk("R6 icp start", icp_first, 3);
    chk("R6 icp not restarted", icp_cnt, 4 * STEP);

    // R2 R7 pass-through in both codes
    for (int code = 2; code < 4; code++) begin
      cfg_src = code[1:0];
      cfg_ocp_copy = 1;
      run_line(0, 2);
      run_line(0, 0);
      chk($sformatf("R2 pass start code=%0d", code), icp_first, 2);
      chk("R2 pass width", icp_cnt, P);
      chk("R7 ocp copies pass-through", ocp_cnt, P);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule